// File: doc/BRIEF.md
# Crystal Clock Output Controller

This block decides when the crystal oscillator has to run and when a divided copy of its clock may appear on the clock output pin. Two independent sources ask for the oscillator: a configuration enable bit and the LED enable pin. The oscillator request is their OR, so the LED dimming logic keeps the crystal running even while the clock output is disabled.

The clock output is released only when three conditions hold. The configuration enable bit must be set. The oscillator must have reported stable and then a further fixed settle wait must have passed. The regulator that feeds the output buffer must be on. Until then the output is held low.

A 2-bit code selects a divide of 1, 2, 4 or 8. The block runs on a reference clock at twice the undivided output rate, so each high or low phase of the output lasts a whole number of reference cycles. A new divide code is taken up only at a low-to-high transition of the output, which keeps every phase at full width.

Top module: `xo_clkout_ctrl`

## Requirements
- R1: `osc_req` goes high one reference cycle after `cfg_clk_en` or `led_en_pin` is high, and goes low one cycle after both are low.
- R2: While `cfg_clk_en` and `osc_stable` stay high together, `ready` rises exactly `SETTLE_CYCLES` clock edges after they first became high at the same time. `led_en_pin` with `osc_stable` high but `cfg_clk_en` low never raises `ready`.
- R3: A low on either `cfg_clk_en` or `osc_stable` drops `ready` at the next edge and clears the wait. A later run needs a fresh full `SETTLE_CYCLES` wait.
- R4: `clk_out` is low from the next edge whenever `ready` is low or `cfg_clk_en` is low.
- R5: With `ldo_on` low, `clk_out` stays low while `osc_req` and `ready` still rise as normal. When `ldo_on` returns, the output restarts with a full low phase.
- R6: `div_sel` sets the half period of `clk_out` in reference cycles: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. After release, `clk_out` is low for one full half period, then toggles every half period.
- R7: A change of `div_sel` while the output runs takes effect at the next low-to-high transition of `clk_out`. Every high or low phase lasts the old or the new half period, never a shorter one.
- R8: During and right after reset, `osc_req`, `ready` and `clk_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, twice the undivided output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Configuration bit enabling the clock output |
| led_en_pin | input | 1 | LED enable pin; also requests the oscillator |
| ldo_on | input | 1 | Regulator feeding the output buffer is on |
| osc_stable | input | 1 | Oscillator reports a stable amplitude |
| div_sel | input | DIV_SEL_W | Divide code: half period is 2^code reference cycles |
| osc_req | output | 1 | Request to run the oscillator |
| clk_out | output | 1 | Divided, gated clock output |
| ready | output | 1 | Post-stable settle wait has completed |

## Verification
All four combinations of the two request sources are applied, which separates an OR from an AND or from a single source. Every divide code is released from a cleared state and compared cycle by cycle against the arithmetic phase formula, which exposes off-by-one counts in both the half period and the first low phase. Drops of the regulator, the enable bit and the stable flag are applied mid-wait and mid-run, showing whether the wait restarts and whether the output restart begins with a full low phase. Divide changes from fast to slow and from slow to fast are applied mid-phase, and every phase width is checked so that a runt pulse cannot hide.

// File: rtl/xo_clkout_pkg.sv
package xo_clkout_pkg;

    localparam int unsigned XO_SETTLE_DEFAULT = 131072;
    localparam int unsigned XO_DIV_SEL_W      = 2;

    typedef struct packed {
        logic req;
    } xo_req_state_t;

endpackage

// File: rtl/xo_req_reg.sv
module xo_req_reg
    import xo_clkout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en_i,
    input  logic led_en_i,
    output logic req_o
);

    xo_req_state_t st_d;
    xo_req_state_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = cfg_en_i | led_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

    assert_req_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (req_o == $past(cfg_en_i | led_en_i)));

endmodule

// File: rtl/xo_settle_timer.sv
module xo_settle_timer #(
    parameter int unsigned LIMIT = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic ready_o
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d;
    tmr_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT_C) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.cnt == LIMIT_C);

    assert_ready_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(run_i));

    assert_drop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> !ready_o);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT_C);

endmodule

// File: rtl/xo_phase_divider.sv
module xo_phase_divider #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             out_o
);

    localparam int unsigned MAX_HALF = 2 ** ((2 ** SEL_W) - 1);
    localparam int unsigned PCNT_W   = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic              out;
        logic [SEL_W-1:0]  sel;
    } div_state_t;

    div_state_t st_d;
    div_state_t st_q;
    logic [PCNT_W-1:0] last_cnt;

    function automatic logic [PCNT_W-1:0] half_m1(input logic [SEL_W-1:0] code);
        return PCNT_W'((1 << code) - 1);
    endfunction

    assign last_cnt = half_m1(st_q.sel);

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.pcnt = '0;
            st_d.out  = 1'b0;
            st_d.sel  = sel_i;
        end else if (st_q.pcnt == last_cnt) begin
            st_d.pcnt = '0;
            st_d.out  = ~st_q.out;
            if (!st_q.out) begin
                st_d.sel = sel_i;
            end
        end else begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    assert_gated_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active_i) |-> !out_o);

    assert_phase_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pcnt <= last_cnt);

    assert_sel_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.out) && st_q.out) |-> $stable(st_q.sel));

endmodule

// File: rtl/xo_clkout_ctrl.sv
module xo_clkout_ctrl
    import xo_clkout_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = XO_SETTLE_DEFAULT,
    parameter int unsigned DIV_SEL_W     = XO_DIV_SEL_W
) (
    input  logic                 clk_ref,
    input  logic                 rst_n,
    input  logic                 cfg_clk_en,
    input  logic                 led_en_pin,
    input  logic                 ldo_on,
    input  logic                 osc_stable,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 osc_req,
    output logic                 clk_out,
    output logic                 ready
);

    logic settle_run;
    logic out_allow;

    assign settle_run = cfg_clk_en & osc_stable;
    assign out_allow  = ready & ldo_on & cfg_clk_en;

    xo_req_reg u_req (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .cfg_en_i (cfg_clk_en),
        .led_en_i (led_en_pin),
        .req_o    (osc_req)
    );

    xo_settle_timer #(
        .LIMIT (SETTLE_CYCLES)
    ) u_timer (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .run_i   (settle_run),
        .ready_o (ready)
    );

    xo_phase_divider #(
        .SEL_W (DIV_SEL_W)
    ) u_div (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .active_i (out_allow),
        .sel_i    (div_sel),
        .out_o    (clk_out)
    );

    assert_ldo_gates_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$past(ldo_on) |-> !clk_out);

    assert_enbit_gates_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !$past(cfg_clk_en) |-> (!clk_out && !ready));

endmodule

// File: tb/xo_clkout_ctrl_bench.sv
module xo_clkout_ctrl_bench;

    localparam int SETTLE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       led = 1'b0;
    logic       ldo = 1'b0;
    logic       stb = 1'b0;
    logic [1:0] div = 2'd0;
    logic       req;
    logic       cout;
    logic       rdy;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    xo_clkout_ctrl #(
        .SETTLE_CYCLES (SETTLE),
        .DIV_SEL_W     (2)
    ) u_xo_clkout_ctrl (
        .clk_ref    (clk),
        .rst_n      (rst_n),
        .cfg_clk_en (en),
        .led_en_pin (led),
        .ldo_on     (ldo),
        .osc_stable (stb),
        .div_sel    (div),
        .osc_req    (req),
        .clk_out    (cout),
        .ready      (rdy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // clear, then enable with the given code; returns when ready has just risen
    task automatic release_with(int code);
        en  = 1'b0;
        ldo = 1'b1;
        stb = 1'b1;
        div = 2'(code);
        tick();
        en = 1'b1;
        repeat (SETTLE) tick();
    endtask

    // run with old code, switch to new code mid-phase, check all phase widths
    task automatic run_change(int oldc, int newc, int pre);
        int prev;
        int len;
        int last_w;
        release_with(oldc);
        prev   = 0;
        len    = 1;
        last_w = 0;
        for (int m = 1; m <= pre + 80; m++) begin
            if (m == pre) div = 2'(newc);
            tick();
            if (int'(cout) == prev) begin
                len++;
            end else begin
                n_run++;
                if (len != (1 << oldc) && len != (1 << newc)) begin
                    n_fail++;
                    $display("FAIL R7: actual width %0d expected %0d or %0d",
                             len, 1 << oldc, 1 << newc);
                end
                last_w = len;
                prev   = int'(cout);
                len    = 1;
            end
        end
        chk("R7 settled width", last_w, 1 << newc);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 req in reset", int'(req), 0);
        chk("R8 out in reset", int'(cout), 0);
        rst_n = 1'b1;
        tick();
        chk("R8 req after reset", int'(req), 0);
        chk("R8 ready after reset", int'(rdy), 0);
        chk("R8 out after reset", int'(cout), 0);

        // R1: OR of both request sources
        for (int k = 0; k < 4; k++) begin
            en  = k[0];
            led = k[1];
            tick();
            chk("R1 request", int'(req), k[0] | k[1]);
        end
        en  = 1'b0;
        led = 1'b0;
        tick();

        // R2: LED pin alone never completes the wait
        led = 1'b1;
        stb = 1'b1;
        repeat (SETTLE + 3) tick();
        chk("R2 led alone ready", int'(rdy), 0);
        chk("R1 led alone req", int'(req), 1);
        led = 1'b0;

        // R2 and R5: exact wait count with the regulator off
        ldo = 1'b0;
        en  = 1'b1;
        repeat (SETTLE - 1) tick();
        chk("R2 one edge early", int'(rdy), 0);
        tick();
        chk("R2 ready on time", int'(rdy), 1);
        for (int m = 0; m < 20; m++) begin
            tick();
            chk("R5 out with ldo off", int'(cout), 0);
        end
        chk("R5 req with ldo off", int'(req), 1);
        chk("R5 ready with ldo off", int'(rdy), 1);

        // R3: stable flag drop restarts the wait
        stb = 1'b0;
        tick();
        chk("R3 ready after stable drop", int'(rdy), 0);
        stb = 1'b1;
        repeat (SETTLE - 1) tick();
        chk("R3 full wait again early", int'(rdy), 0);
        tick();
        chk("R3 full wait again", int'(rdy), 1);

        // R3: a partial wait is discarded
        en = 1'b0;
        tick();
        en = 1'b1;
        repeat (SETTLE - 3) tick();
        en = 1'b0;
        tick();
        chk("R3 ready after en drop", int'(rdy), 0);
        en = 1'b1;
        repeat (SETTLE - 1) tick();
        chk("R3 partial not kept", int'(rdy), 0);
        tick();
        chk("R3 ready after restart", int'(rdy), 1);

        // R6: every divide code against the phase formula
        for (int c = 0; c < 4; c++) begin
            release_with(c);
            chk("R6 ready at release", int'(rdy), 1);
            chk("R4 low before release", int'(cout), 0);
            for (int m = 1; m <= 6 * (1 << c); m++) begin
                tick();
                chk($sformatf("R6 code %0d step %0d", c, m), int'(cout), (m >> c) & 1);
            end
        end

        // R5: regulator drop mid-run and full-low restart
        release_with(2);
        repeat (6) tick();
        ldo = 1'b0;
        for (int m = 0; m < 6; m++) begin
            tick();
            chk("R5 out after ldo drop", int'(cout), 0);
        end
        chk("R5 ready kept", int'(rdy), 1);
        ldo = 1'b1;
        for (int m = 1; m <= 16; m++) begin
            tick();
            chk("R5 restart phase", int'(cout), (m >> 2) & 1);
        end

        // R4: enable bit drop with the LED still requesting
        led = 1'b1;
        repeat (2) tick();
        en = 1'b0;
        tick();
        chk("R4 out after en drop", int'(cout), 0);
        chk("R4 ready after en drop", int'(rdy), 0);
        chk("R1 req held by led", int'(req), 1);
        for (int m = 0; m < 10; m++) begin
            tick();
            chk("R4 out held low", int'(cout), 0);
        end
        led = 1'b0;

        // R7: divide changes in both directions, mid-phase
        run_change(1, 3, 7);
        run_change(3, 0, 13);
        run_change(0, 2, 4);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule